// File: doc/BRIEF.md
# Four-Channel DAC Register Write Decoder on a Two-Wire Serial Bus

This block is the write side of a two-wire serial (I2C) slave that controls a bank of four 8-bit converter channels. It samples the clock and data lines with the system clock and detects START, repeated START and STOP conditions. It matches the first byte of each transfer against a fixed five-bit prefix and two strap pins. It acknowledges each byte it accepts by pulling the data line low during the ninth clock.

The byte after the address is a command byte. It carries two more strap-matched address bits, a load mode, a channel select and a power-down flag. When the flag is clear, the command is followed by any number of byte pairs. The first byte of each pair is the new code and the second byte is discarded. Each completed pair writes the selected channel's buffer and, depending on the load mode, also updates one output or all four outputs. When the flag is set, exactly one pair follows, and it carries a two-bit power-down code for the selected channel. A repeated START begins a fresh transfer at the address stage.

Top module: `qdac_i2c_writer`

## Requirements
- R1: After reset every channel output code is 0, every power-down code is 0, and the data line is not driven.
- R2: The address byte is accepted and acknowledged only when it equals 1,0,0,1,1,A1,A0,0 (MSB first), where A1:A0 equal `addr_pin_i[1:0]`. On any other address, including one with the read bit (LSB) set, there is no acknowledge, and no byte is acknowledged or acted on until the next START or STOP.
- R3: The command byte is acknowledged only when its bits [7:6] equal `ext_addr_i[1:0]`. Otherwise it is not acknowledged, and no byte is acknowledged or acted on until the next START or STOP.
- R4: The command byte fields are as follows. Bits [5:4] are the load mode, bit [3] is ignored, bits [2:1] select the channel, and bit [0] selects power-down when it is 1. With bit [0] = 0 and load mode 00, each acknowledged pair stores its first byte into the selected channel's buffer only. The outputs stay unchanged, and the second byte has no effect.
- R5: With load mode 01, a completed pair updates the selected channel's buffer, and that channel's output takes the new code.
- R6: With load mode 10, a completed pair updates the selected channel's buffer, and then all four outputs take their buffer values at once.
- R7: With bit [0] = 0, pairs keep being acknowledged and applied to the same channel with the same mode until STOP or repeated START. The last pair's code is the one that remains.
- R8: A repeated START returns the decoder to the address stage, so a new address and command byte are accepted without a STOP in between.
- R9: With bit [0] = 1, a first byte with bits [5:0] = 0 and a second byte are acknowledged. The selected channel's power-down code becomes {bit7, bit6} of the first byte, on `pdm_o[2c+1:2c]`. The output codes are unchanged. Any further byte before START or STOP is not acknowledged.
- R10: In power-down mode, a first byte with any of bits [5:0] set is not acknowledged, and the power-down codes stay unchanged.
- R11: The slave changes its data-line drive only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pin_i | input | 2 | Strap bits A1:A0 compared in the address byte |
| ext_addr_i | input | 2 | Strap bits compared with command byte bits [7:6] |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| code_o | output | 8*NCH | Output code per channel, channel c at [8c+7:8c] |
| pdm_o | output | 2*NCH | Power-down code per channel, channel c at [2c+1:2c] |

## Verification
The bench builds the block with its default values: four channels and two synchronizer stages. The address strap is set to 10 and the command strap to 01, so both matching and non-matching bytes can be driven. With four channels, the all-outputs load can be checked against a mix of buffers that were written but never loaded. The bench runs each bus bit over 32 system clocks. This leaves room for the synchronizer and edge-detect delay before the acknowledge is sampled while the clock line is high.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_PREFIX = 5'b10011;

    localparam logic [1:0] LD_BUF = 2'b00;
    localparam logic [1:0] LD_ONE = 2'b01;
    localparam logic [1:0] LD_ALL = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_DHI,
        ST_DLO,
        ST_PHI,
        ST_PLO,
        ST_IGN
    } link_st_t;
endpackage

// File: rtl/qdac_bus_sense.sv
module qdac_bus_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl_c;
        logic [STAGES-1:0] sda_c;
        logic              scl_p;
        logic              sda_p;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl_c = {s_q.scl_c[STAGES-2:0], scl_i};
        s_d.sda_c = {s_q.sda_c[STAGES-2:0], sda_i};
        s_d.scl_p = s_q.scl_c[STAGES-1];
        s_d.sda_p = s_q.sda_c[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s    = s_q.scl_c[STAGES-1];
    assign sda_s    = s_q.sda_c[STAGES-1];
    assign scl_rise = scl_s && !s_q.scl_p;
    assign scl_fall = !scl_s && s_q.scl_p;
    assign start_ev = scl_s && s_q.scl_p && s_q.sda_p && !sda_s;
    assign stop_ev  = scl_s && s_q.scl_p && !s_q.sda_p && sda_s;
endmodule

// File: rtl/qdac_link.sv
module qdac_link
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [1:0]        addr_pin_i,
    input  logic [1:0]        ext_addr_i,
    output logic              ack_o,
    output link_st_t          st_o,
    output logic              wr_en,
    output logic [1:0]        wr_sel,
    output logic [1:0]        wr_load,
    output logic [BYTE_W-1:0] wr_code,
    output logic              pd_en,
    output logic [1:0]        pd_val
);
    typedef struct packed {
        link_st_t          st;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] hi;
        logic              ack;
        logic [1:0]        sel;
        logic [1:0]        load;
        logic              pdm;
    } link_t;

    link_t l_d, l_q;
    logic  ok;

    function automatic link_st_t after(link_st_t s, logic pdm);
        case (s)
            ST_ADDR: after = ST_CTRL;
            ST_CTRL: after = pdm ? ST_PHI : ST_DHI;
            ST_DHI:  after = ST_DLO;
            ST_DLO:  after = ST_DHI;
            ST_PHI:  after = ST_PLO;
            default: after = ST_IGN;
        endcase
    endfunction

    always_comb begin
        l_d   = l_q;
        ok    = 1'b0;
        wr_en = 1'b0;
        pd_en = 1'b0;
        if (stop_ev) begin
            l_d.st  = ST_IDLE;
            l_d.cnt = 4'd0;
            l_d.ack = 1'b0;
        end else if (start_ev) begin
            l_d.st  = ST_ADDR;
            l_d.cnt = 4'd0;
            l_d.ack = 1'b0;
        end else if (l_q.st != ST_IDLE && l_q.st != ST_IGN) begin
            if (scl_rise && l_q.cnt < 4'd8) begin
                l_d.sh  = {l_q.sh[BYTE_W-2:0], sda_s};
                l_d.cnt = l_q.cnt + 4'd1;
            end else if (scl_rise && l_q.cnt == 4'd8) begin
                l_d.cnt = 4'd9;
            end else if (scl_fall && l_q.cnt == 4'd8) begin
                case (l_q.st)
                    ST_ADDR: ok = (l_q.sh[7:1] == {DEV_PREFIX, addr_pin_i}) && !l_q.sh[0];
                    ST_CTRL: begin
                        ok = (l_q.sh[7:6] == ext_addr_i);
                        l_d.load = l_q.sh[5:4];
                        l_d.sel  = l_q.sh[2:1];
                        l_d.pdm  = l_q.sh[0];
                    end
                    ST_DHI: begin
                        ok = 1'b1;
                        l_d.hi = l_q.sh;
                    end
                    ST_DLO: begin
                        ok = 1'b1;
                        wr_en = 1'b1;
                    end
                    ST_PHI: begin
                        ok = (l_q.sh[5:0] == 6'd0);
                        l_d.hi = l_q.sh;
                    end
                    ST_PLO: begin
                        ok = 1'b1;
                        pd_en = 1'b1;
                    end
                    default: ok = 1'b0;
                endcase
                if (ok) begin
                    l_d.ack = 1'b1;
                end else begin
                    l_d.st  = ST_IGN;
                    l_d.cnt = 4'd0;
                end
            end else if (scl_fall && l_q.cnt == 4'd9) begin
                l_d.ack = 1'b0;
                l_d.cnt = 4'd0;
                l_d.st  = after(l_q.st, l_q.pdm);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q     <= '0;
            l_q.st  <= ST_IDLE;
        end else begin
            l_q <= l_d;
        end
    end

    assign ack_o   = l_q.ack;
    assign st_o    = l_q.st;
    assign wr_sel  = l_q.sel;
    assign wr_load = l_q.load;
    assign wr_code = l_q.hi;
    assign pd_val  = l_q.hi[7:6];
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [1:0]            wr_load,
    input  logic [BYTE_W-1:0]     wr_code,
    input  logic                  pd_en,
    input  logic [1:0]            pd_val,
    output logic [NCH*BYTE_W-1:0] code_o,
    output logic [2*NCH-1:0]      pdm_o
);
    typedef struct packed {
        logic [NCH-1:0][BYTE_W-1:0] bufr;
        logic [NCH-1:0][BYTE_W-1:0] outr;
        logic [NCH-1:0][1:0]        pdr;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (wr_en) begin
            b_d.bufr[wr_sel] = wr_code;
            if (wr_load == LD_ONE) begin
                b_d.outr[wr_sel] = wr_code;
            end else if (wr_load == LD_ALL) begin
                for (int c = 0; c < NCH; c++) begin
                    b_d.outr[c] = (c == int'(wr_sel)) ? wr_code : b_q.bufr[c];
                end
            end
        end
        if (pd_en) begin
            b_d.pdr[wr_sel] = pd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_pack
        assign code_o[g*BYTE_W +: BYTE_W] = b_q.outr[g];
        assign pdm_o[2*g +: 2]            = b_q.pdr[g];
    end
endmodule

// File: rtl/qdac_i2c_writer.sv
module qdac_i2c_writer
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [1:0]            addr_pin_i,
    input  logic [1:0]            ext_addr_i,
    output logic                  sda_oe_o,
    output logic [NCH*BYTE_W-1:0] code_o,
    output logic [2*NCH-1:0]      pdm_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    link_st_t          link_st;
    logic              wr_en, pd_en;
    logic [1:0]        wr_sel, wr_load, pd_val;
    logic [BYTE_W-1:0] wr_code;

    qdac_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    qdac_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .addr_pin_i (addr_pin_i),
        .ext_addr_i (ext_addr_i),
        .ack_o      (sda_oe_o),
        .st_o       (link_st),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_load    (wr_load),
        .wr_code    (wr_code),
        .pd_en      (pd_en),
        .pd_val     (pd_val)
    );

    qdac_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_load (wr_load),
        .wr_code (wr_code),
        .pd_en   (pd_en),
        .pd_val  (pd_val),
        .code_o  (code_o),
        .pdm_o   (pdm_o)
    );
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk
    import qdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_ev,
    input logic                  stop_ev,
    input logic                  sda_oe_o,
    input logic [NCH*BYTE_W-1:0] code_o,
    input logic [2*NCH-1:0]      pdm_o,
    input logic                  wr_en,
    input logic                  pd_en,
    input link_st_t              link_st
);
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);                                   // R11
    AST_CODE_ONLY_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> $past(wr_en));                               // R5
    AST_PD_ONLY_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pdm_o) |-> $past(pd_en));                                // R9
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (link_st == ST_IGN) |-> !sda_oe_o);                               // R2
    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (link_st == ST_ADDR) && !sda_oe_o);                  // R8
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o && (link_st == ST_IDLE));                   // R7
endmodule

bind qdac_i2c_writer qdac_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe_o (sda_oe_o),
    .code_o   (code_o),
    .pdm_o    (pdm_o),
    .wr_en    (wr_en),
    .pd_en    (pd_en),
    .link_st  (link_st)
);

// File: tb/qdac_i2c_writer_tb.sv
module qdac_i2c_writer_tb;
    localparam int NCH = 4;
    localparam int Q   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_pin = 2'b10;
    logic [1:0] ext_addr = 2'b01;
    logic sda_oe;
    logic [NCH*8-1:0] code;
    logic [2*NCH-1:0] pdm;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        string            tag;
        logic [NCH*8-1:0] exp_code;
        logic [2*NCH-1:0] exp_pd;
    } item_t;
    item_t sbq[$];

    logic [7:0] m_buf [NCH];
    logic [7:0] m_out [NCH];
    logic [1:0] m_pd  [NCH];

    localparam logic [7:0] ADDR_OK = 8'h9C;

    always #10 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    qdac_i2c_writer #(.NCH(NCH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_pin_i (addr_pin),
        .ext_addr_i (ext_addr),
        .sda_oe_o   (sda_oe),
        .code_o     (code),
        .pdm_o      (pdm)
    );

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_expect(string tag);
        item_t it;
        it.tag = tag;
        for (int c = 0; c < NCH; c++) begin
            it.exp_code[c*8 +: 8] = m_out[c];
            it.exp_pd[c*2 +: 2]   = m_pd[c];
        end
        sbq.push_back(it);
        cyc(4);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        sda_m = 1'b1; cyc(3*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(Q);
            scl_m = 1'b1; cyc(2*Q);
            scl_m = 1'b0; cyc(Q);
        end
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(Q);
        @(negedge clk);
        got = ~sda_bus;
        cyc(Q);
        scl_m = 1'b0; cyc(Q);
        check(tag, {63'd0, got}, {63'd0, exp_ack});
    endtask

    function automatic logic [7:0] ctrl(logic [1:0] hi, logic [1:0] ld, logic [1:0] sel, logic pd);
        return {hi, ld, 1'b0, sel, pd};
    endfunction

    task automatic m_pair(logic [1:0] ld, logic [1:0] sel, logic [7:0] v);
        m_buf[sel] = v;
        if (ld == 2'b01) m_out[sel] = v;
        else if (ld == 2'b10) for (int c = 0; c < NCH; c++) m_out[c] = m_buf[c];
    endtask

    // full data write of one pair
    task automatic wr_one(logic [1:0] ld, logic [1:0] sel, logic [7:0] v, string tag);
        bus_start();
        send_byte(ADDR_OK, 1'b1, {tag, " addr ack"});
        send_byte(ctrl(2'b01, ld, sel, 1'b0), 1'b1, {tag, " ctrl ack"});
        send_byte(v, 1'b1, {tag, " hi ack"});
        send_byte(8'hFF, 1'b1, {tag, " lo ack"});
        bus_stop();
        m_pair(ld, sel, v);
        push_expect(tag);
    endtask

    // monitor: compares scoreboard entries against outputs
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sbq.size() != 0) begin
                it = sbq.pop_front();
                check({it.tag, " code"}, {32'd0, code}, {32'd0, it.exp_code});
                check({it.tag, " pd"}, {56'd0, pdm}, {56'd0, it.exp_pd});
            end
        end
    end

    // R11: drive changes only while clock line low
    int drive_bad = 0;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) drive_bad++;
        oe_prev <= sda_oe;
    end

    initial begin
        cyc(200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_buf[c] = 8'h00; m_out[c] = 8'h00; m_pd[c] = 2'b00;
        end
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        @(negedge clk);
        check("R1 reset oe", {63'd0, sda_oe}, 64'd0);
        push_expect("R1 reset");

        wr_one(2'b00, 2'd1, 8'h5A, "R4 buffer only");
        wr_one(2'b01, 2'd2, 8'h33, "R5 load one");
        wr_one(2'b00, 2'd0, 8'h11, "R4 buffer ch0");
        wr_one(2'b00, 2'd3, 8'h44, "R4 buffer ch3");
        wr_one(2'b10, 2'd1, 8'h77, "R6 load all");

        // R7 stream of pairs
        bus_start();
        send_byte(ADDR_OK, 1'b1, "R7 addr ack");
        send_byte(ctrl(2'b01, 2'b01, 2'd0, 1'b0), 1'b1, "R7 ctrl ack");
        for (int k = 1; k <= 3; k++) begin
            send_byte(8'h80 + 8'(k), 1'b1, "R7 stream hi ack");
            send_byte(8'h00, 1'b1, "R7 stream lo ack");
            m_pair(2'b01, 2'd0, 8'h80 + 8'(k));
        end
        bus_stop();
        push_expect("R7 stream");

        // R8 repeated start
        bus_start();
        send_byte(ADDR_OK, 1'b1, "R8 addr ack");
        send_byte(ctrl(2'b01, 2'b01, 2'd3, 1'b0), 1'b1, "R8 ctrl ack");
        send_byte(8'h99, 1'b1, "R8 hi ack");
        send_byte(8'h12, 1'b1, "R8 lo ack");
        m_pair(2'b01, 2'd3, 8'h99);
        bus_start();
        send_byte(ADDR_OK, 1'b1, "R8 re-addr ack");
        send_byte(ctrl(2'b01, 2'b01, 2'd1, 1'b0), 1'b1, "R8 re-ctrl ack");
        send_byte(8'hA5, 1'b1, "R8 re-hi ack");
        send_byte(8'h00, 1'b1, "R8 re-lo ack");
        m_pair(2'b01, 2'd1, 8'hA5);
        bus_stop();
        push_expect("R8 restart");

        // R2 address mismatch and read bit
        bus_start();
        send_byte(8'h9E, 1'b0, "R2 wrong strap nack");
        send_byte(ctrl(2'b01, 2'b01, 2'd2, 1'b0), 1'b0, "R2 ignored ctrl");
        send_byte(8'hEE, 1'b0, "R2 ignored hi");
        send_byte(8'h00, 1'b0, "R2 ignored lo");
        bus_stop();
        push_expect("R2 mismatch no effect");
        bus_start();
        send_byte(8'h9D, 1'b0, "R2 read bit nack");
        bus_stop();

        // R3 command strap mismatch
        bus_start();
        send_byte(ADDR_OK, 1'b1, "R3 addr ack");
        send_byte(ctrl(2'b10, 2'b01, 2'd2, 1'b0), 1'b0, "R3 ctrl nack");
        send_byte(8'hEE, 1'b0, "R3 ignored hi");
        send_byte(8'h00, 1'b0, "R3 ignored lo");
        bus_stop();
        push_expect("R3 mismatch no effect");

        // R9 power-down pair
        bus_start();
        send_byte(ADDR_OK, 1'b1, "R9 addr ack");
        send_byte(ctrl(2'b01, 2'b00, 2'd2, 1'b1), 1'b1, "R9 ctrl ack");
        send_byte(8'b1000_0000, 1'b1, "R9 pd hi ack");
        send_byte(8'h5C, 1'b1, "R9 pd lo ack");
        send_byte(8'h00, 1'b0, "R9 extra byte nack");
        bus_stop();
        m_pd[2] = 2'b10;
        push_expect("R9 pd ch2");

        bus_start();
        send_byte(ADDR_OK, 1'b1, "R9 addr ack b");
        send_byte(ctrl(2'b01, 2'b00, 2'd0, 1'b1), 1'b1, "R9 ctrl ack b");
        send_byte(8'hC0, 1'b1, "R9 pd hi ack b");
        send_byte(8'h00, 1'b1, "R9 pd lo ack b");
        bus_stop();
        m_pd[0] = 2'b11;
        push_expect("R9 pd ch0");

        // R10 nonzero reserved bits
        bus_start();
        send_byte(ADDR_OK, 1'b1, "R10 addr ack");
        send_byte(ctrl(2'b01, 2'b00, 2'd3, 1'b1), 1'b1, "R10 ctrl ack");
        send_byte(8'h41, 1'b0, "R10 pd hi nack");
        send_byte(8'h00, 1'b0, "R10 lo ignored");
        bus_stop();
        push_expect("R10 pd unchanged");

        cyc(20);
        check("R11 drive changes with clock high", 64'(drive_bad), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule